// File: doc/BRIEF.md
# Conditional Skip and Jump Evaluator

This block decides the control-flow outcome of a conditional instruction. It receives the tested register value, a second operand, a condition code, a negate bit, a skip distance bit, a signed/unsigned comparison bit, an absolute jump address and the current next-instruction pointer. From these it tells the fetch stage one of three things. It may request a short forward skip of one or two half-words. It may request a jump to an absolute address. It may request nothing.

Bit-level tests (zero, lowest bit, highest bit) sit beside magnitude comparisons. A magnitude comparison is a subtraction of the operand from the tested value, and can be signed or unsigned. Any condition may be inverted. An unconditional jump whose negate bit is set is a jump-and-link: the jump is always taken, and the next-instruction pointer is offered as the link value for write-back. All outputs are registered and appear one cycle after the instruction is presented.

Top module: `cond_branch_eval`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, outValid, skipEn, jumpEn and linkEn are 0, and skipCount, jumpTarget and linkValue are 0.
- R2: The outputs for an instruction presented with instValid=1 appear in the next cycle with outValid=1. After a cycle with instValid=0, outValid, skipEn, jumpEn and linkEn are all 0.
- R3: condCode 0 is always true. Code 1 is true when testVal is zero, code 2 when bit 0 of testVal is 1, and code 3 when the top bit of testVal is 1.
- R4: With signedCmp=0, codes 4, 5, 6 and 7 test testVal above, below, above-or-equal and below-or-equal operand, treating both as unsigned.
- R5: With signedCmp=1, codes 4 to 7 make the same tests, treating both values as two's complement.
- R6: negate=1 inverts the result of every condition, except in the jump-and-link case of R9.
- R7: For a skip (isJump=0), a true condition gives skipEn=1 with skipCount=1 when skipFar=0 and skipCount=2 when skipFar=1. A false condition gives skipEn=0 and skipCount=0. A skip never raises jumpEn.
- R8: For a jump (isJump=1), a true condition gives jumpEn=1 with jumpTarget equal to targetAddr. A false condition gives jumpEn=0 and jumpTarget=0. A jump never raises skipEn.
- R9: A jump with condCode 0 and negate=1 always jumps to targetAddr, sets linkEn=1 and gives linkValue equal to nextIp. linkEn is 0 for every other instruction.
- R10: A skip with condCode 0 and negate=1 produces neither a skip nor a jump: skipEn=0, skipCount=0, jumpEn=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | A conditional instruction is presented this cycle |
| isJump | input | 1 | 1 = jump kind, 0 = skip kind |
| condCode | input | 3 | Condition select (see R3 to R5) |
| negate | input | 1 | Invert the condition |
| skipFar | input | 1 | Skip distance: 0 = one half-word, 1 = two |
| signedCmp | input | 1 | Magnitude conditions compare as signed |
| testVal | input | DATA_W | Tested register value |
| operand | input | DATA_W | Second comparison operand |
| targetAddr | input | ADDR_W | Absolute jump address from a register |
| nextIp | input | ADDR_W | Current next-instruction pointer |
| outValid | output | 1 | Registered outputs belong to an instruction |
| skipEn | output | 1 | Skip requested |
| skipCount | output | 2 | Half-words to skip (0 when no skip) |
| jumpEn | output | 1 | Jump requested |
| jumpTarget | output | ADDR_W | Jump address (0 when no jump) |
| linkEn | output | 1 | Link value must be written back |
| linkValue | output | ADDR_W | Next-instruction pointer to save |

## Verification
Two functions fire in the same cycle in exactly one case: the jump request and the link request, both raised by a jump-and-link. The bench provokes this by issuing an unconditional jump with negate set. It does so between back-to-back conditional instructions, so that a stale link or a stale target would show in the neighbouring results. It then judges that jumpEn and linkEn rise in the same output cycle, with jumpTarget equal to the presented address and linkValue equal to the presented pointer. It also checks that the neighbouring results show no link at all. The same encoding on a skip is issued right next to it, and must yield no action, so that a swapped kind decode would be caught.

// File: rtl/cbe_pkg.sv
package cbe_pkg;

  localparam int CondCount = 8;
  localparam int CntW      = 2;

  typedef enum logic [2:0] {
    CondAlways  = 3'd0,
    CondZero    = 3'd1,
    CondLsb     = 3'd2,
    CondMsb     = 3'd3,
    CondAbove   = 3'd4,
    CondBelow   = 3'd5,
    CondAboveEq = 3'd6,
    CondBelowEq = 3'd7
  } condE;

  // strobes from control to datapath
  typedef struct packed {
    logic                 load;
    logic                 kindJump;
    logic                 far;
    logic                 useSigned;
    logic                 invert;
    logic                 linkReq;
    logic [CondCount-1:0] condSel;
  } strobeT;

endpackage

// File: rtl/cbe_ctrl.sv
module cbe_ctrl
  import cbe_pkg::*;
(
  input  logic       instValid,
  input  logic       isJump,
  input  logic [2:0] condCode,
  input  logic       negate,
  input  logic       skipFar,
  input  logic       signedCmp,
  output strobeT     strobe
);

  logic linkCase;

  // unconditional jump with negate set is jump-and-link
  assign linkCase = isJump && (condE'(condCode) == CondAlways) && negate;

  always_comb begin
    strobe           = '0;
    strobe.load      = instValid;
    strobe.kindJump  = isJump;
    strobe.far       = skipFar;
    strobe.useSigned = signedCmp;
    strobe.invert    = negate && !linkCase;
    strobe.linkReq   = instValid && linkCase;
    for (int i = 0; i < CondCount; i++) begin
      strobe.condSel[i] = (condCode == 3'(i));
    end
  end

endmodule

// File: rtl/cbe_datapath.sv
module cbe_datapath
  import cbe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobeT            strobe,
  input  logic [DATA_W-1:0] testVal,
  input  logic [DATA_W-1:0] operand,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [ADDR_W-1:0] nextIp,
  output logic              outValid,
  output logic              skipEn,
  output logic [CntW-1:0]   skipCount,
  output logic              jumpEn,
  output logic [ADDR_W-1:0] jumpTarget,
  output logic              linkEn,
  output logic [ADDR_W-1:0] linkValue
);

  localparam logic [DATA_W-1:0] SignBit = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0]   aBiased, bBiased;
  logic [DATA_W:0]     diff;
  logic                borrow, isEqual, isZero;
  logic [CondCount-1:0] flags;
  logic                hit, taken, doSkip, doJump;

  // signed compare by offsetting both values, then one unsigned subtract
  assign aBiased = strobe.useSigned ? (testVal ^ SignBit) : testVal;
  assign bBiased = strobe.useSigned ? (operand ^ SignBit) : operand;
  assign diff    = {1'b0, aBiased} - {1'b0, bBiased};
  assign borrow  = diff[DATA_W];
  assign isEqual = ~|diff[DATA_W-1:0];
  assign isZero  = ~|testVal;

  always_comb begin
    flags               = '0;
    flags[CondAlways]   = 1'b1;
    flags[CondZero]     = isZero;
    flags[CondLsb]      = testVal[0];
    flags[CondMsb]      = testVal[DATA_W-1];
    flags[CondAbove]    = !borrow && !isEqual;
    flags[CondBelow]    = borrow;
    flags[CondAboveEq]  = !borrow;
    flags[CondBelowEq]  = borrow || isEqual;
  end

  assign hit    = |(flags & strobe.condSel);
  assign taken  = hit ^ strobe.invert;
  assign doSkip = strobe.load && !strobe.kindJump && taken;
  assign doJump = strobe.load && strobe.kindJump && taken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid   <= 1'b0;
      skipEn     <= 1'b0;
      skipCount  <= '0;
      jumpEn     <= 1'b0;
      jumpTarget <= '0;
      linkEn     <= 1'b0;
      linkValue  <= '0;
    end else begin
      outValid   <= strobe.load;
      skipEn     <= doSkip;
      skipCount  <= doSkip ? (strobe.far ? CntW'(2) : CntW'(1)) : '0;
      jumpEn     <= doJump;
      jumpTarget <= doJump ? targetAddr : '0;
      linkEn     <= strobe.linkReq;
      linkValue  <= strobe.linkReq ? nextIp : '0;
    end
  end

endmodule

// File: rtl/cond_branch_eval.sv
module cond_branch_eval
  import cbe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instValid,
  input  logic              isJump,
  input  logic [2:0]        condCode,
  input  logic              negate,
  input  logic              skipFar,
  input  logic              signedCmp,
  input  logic [DATA_W-1:0] testVal,
  input  logic [DATA_W-1:0] operand,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [ADDR_W-1:0] nextIp,
  output logic              outValid,
  output logic              skipEn,
  output logic [1:0]        skipCount,
  output logic              jumpEn,
  output logic [ADDR_W-1:0] jumpTarget,
  output logic              linkEn,
  output logic [ADDR_W-1:0] linkValue
);

  strobeT strobe;

  cbe_ctrl u_ctrl (
    .instValid (instValid),
    .isJump    (isJump),
    .condCode  (condCode),
    .negate    (negate),
    .skipFar   (skipFar),
    .signedCmp (signedCmp),
    .strobe    (strobe)
  );

  cbe_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .testVal    (testVal),
    .operand    (operand),
    .targetAddr (targetAddr),
    .nextIp     (nextIp),
    .outValid   (outValid),
    .skipEn     (skipEn),
    .skipCount  (skipCount),
    .jumpEn     (jumpEn),
    .jumpTarget (jumpTarget),
    .linkEn     (linkEn),
    .linkValue  (linkValue)
  );

endmodule

// File: rtl/cbe_checker.sv
module cbe_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instValid,
  input logic              isJump,
  input logic [2:0]        condCode,
  input logic              negate,
  input logic [ADDR_W-1:0] nextIp,
  input logic              outValid,
  input logic              skipEn,
  input logic [1:0]        skipCount,
  input logic              jumpEn,
  input logic              linkEn,
  input logic [ADDR_W-1:0] linkValue
);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    instValid |=> outValid);

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !instValid |=> (!outValid && !skipEn && !jumpEn && !linkEn));

  p_count_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !skipEn |-> (skipCount == 2'd0));

  p_count_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    skipEn |-> (skipCount == 2'd1 || skipCount == 2'd2));

  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(skipEn && jumpEn));

  p_link_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && isJump && condCode == 3'd0 && negate) |=>
      (jumpEn && linkEn && linkValue == $past(nextIp)));

  p_link_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    linkEn |-> jumpEn);

  p_never_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && !isJump && condCode == 3'd0 && negate) |=>
      (!skipEn && !jumpEn && skipCount == 2'd0));

endmodule

bind cond_branch_eval cbe_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .instValid (instValid),
  .isJump    (isJump),
  .condCode  (condCode),
  .negate    (negate),
  .nextIp    (nextIp),
  .outValid  (outValid),
  .skipEn    (skipEn),
  .skipCount (skipCount),
  .jumpEn    (jumpEn),
  .linkEn    (linkEn),
  .linkValue (linkValue)
);

// File: tb/cond_branch_eval_tb_top.sv
`timescale 1ns/1ps
module cond_branch_eval_tb_top;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         instValid = 1'b0, isJump = 1'b0, negate = 1'b0;
  logic         skipFar = 1'b0, signedCmp = 1'b0;
  logic [2:0]   condCode = '0;
  logic [W-1:0] testVal = '0, operand = '0, targetAddr = '0, nextIp = '0;
  logic         outValid, skipEn, jumpEn, linkEn;
  logic [1:0]   skipCount;
  logic [W-1:0] jumpTarget, linkValue;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic         se;
    logic [1:0]   sc;
    logic         je;
    logic [W-1:0] jt;
    logic         le;
    logic [W-1:0] lv;
    string        tag;
  } expT;

  expT sb[$];

  always #2.5 clk = ~clk;

  cond_branch_eval #(.DATA_W(W), .ADDR_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .instValid(instValid), .isJump(isJump),
    .condCode(condCode), .negate(negate), .skipFar(skipFar),
    .signedCmp(signedCmp), .testVal(testVal), .operand(operand),
    .targetAddr(targetAddr), .nextIp(nextIp), .outValid(outValid),
    .skipEn(skipEn), .skipCount(skipCount), .jumpEn(jumpEn),
    .jumpTarget(jumpTarget), .linkEn(linkEn), .linkValue(linkValue)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model written from the requirements
  function automatic expT model(logic j, logic [2:0] c, logic n, logic f,
                                logic s, logic [W-1:0] a, logic [W-1:0] b,
                                logic [W-1:0] t, logic [W-1:0] ip, string tag);
    expT e;
    logic cond, tk;
    e = '{se:0, sc:0, je:0, jt:0, le:0, lv:0, tag:tag};
    case (c)
      3'd0: cond = 1'b1;
      3'd1: cond = (a == 0);
      3'd2: cond = a[0];
      3'd3: cond = a[W-1];
      3'd4: cond = s ? ($signed(a) >  $signed(b)) : (a >  b);
      3'd5: cond = s ? ($signed(a) <  $signed(b)) : (a <  b);
      3'd6: cond = s ? ($signed(a) >= $signed(b)) : (a >= b);
      default: cond = s ? ($signed(a) <= $signed(b)) : (a <= b);
    endcase
    if (j && c == 3'd0 && n) begin
      e.je = 1; e.jt = t; e.le = 1; e.lv = ip;
    end else begin
      tk = cond ^ n;
      if (j) begin e.je = tk; e.jt = tk ? t : '0; end
      else   begin e.se = tk; e.sc = tk ? (f ? 2'd2 : 2'd1) : 2'd0; end
    end
    return e;
  endfunction

  // driver: presents one instruction for one cycle and records the expectation
  task automatic issue(logic j, logic [2:0] c, logic n, logic f, logic s,
                       logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] t,
                       logic [W-1:0] ip, string tag);
    instValid = 1; isJump = j; condCode = c; negate = n; skipFar = f;
    signedCmp = s; testVal = a; operand = b; targetAddr = t; nextIp = ip;
    sb.push_back(model(j, c, n, f, s, a, b, t, ip, tag));
    @(negedge clk);
    instValid = 0;
  endtask

  // monitor: compares registered results at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && outValid) begin
        if (sb.size() == 0) begin
          check("R2 unexpected result", 1, 0);
        end else begin
          expT e;
          e = sb.pop_front();
          check({e.tag, " skipEn"},     W'(skipEn),    W'(e.se));
          check({e.tag, " skipCount"},  W'(skipCount), W'(e.sc));
          check({e.tag, " jumpEn"},     W'(jumpEn),    W'(e.je));
          check({e.tag, " jumpTarget"}, jumpTarget,    e.jt);
          check({e.tag, " linkEn"},     W'(linkEn),    W'(e.le));
          check({e.tag, " linkValue"},  linkValue,     e.lv);
        end
      end else if (rst_n && (skipEn || jumpEn || linkEn)) begin
        check("R2 idle enables", W'({skipEn, jumpEn, linkEn}), '0);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outValid in reset", W'(outValid), 0);
    check("R1 enables in reset", W'({skipEn, jumpEn, linkEn}), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", W'({outValid, skipEn, jumpEn, linkEn}), 0);
    check("R1 values after reset", jumpTarget | linkValue | W'(skipCount), 0);

    // bit-level conditions
    issue(0, 3'd1, 0, 0, 0, 16'h0000, 16'h1234, 16'h0, 16'h10, "R3 zero true near R7");
    issue(0, 3'd1, 0, 1, 0, 16'h0100, 16'h0,    16'h0, 16'h10, "R3 zero false R7");
    issue(0, 3'd2, 0, 1, 0, 16'h0003, 16'h0,    16'h0, 16'h10, "R3 lsb far R7");
    issue(0, 3'd3, 0, 0, 0, 16'h8000, 16'h0,    16'h0, 16'h10, "R3 msb true");
    issue(0, 3'd3, 0, 0, 0, 16'h7fff, 16'h0,    16'h0, 16'h10, "R3 msb false");
    @(negedge clk);
    // unsigned versus signed at the sign boundary
    issue(0, 3'd4, 0, 0, 0, 16'h8000, 16'h0001, 16'h0, 16'h0, "R4 unsigned above");
    issue(0, 3'd4, 0, 0, 1, 16'h8000, 16'h0001, 16'h0, 16'h0, "R5 signed above");
    issue(0, 3'd5, 0, 1, 1, 16'hffff, 16'h0000, 16'h0, 16'h0, "R5 signed below");
    issue(0, 3'd6, 0, 0, 0, 16'h1234, 16'h1234, 16'h0, 16'h0, "R4 above-or-equal on equal");
    issue(0, 3'd7, 0, 0, 1, 16'h1234, 16'h1234, 16'h0, 16'h0, "R5 below-or-equal on equal");
    issue(0, 3'd4, 1, 0, 0, 16'h1234, 16'h1234, 16'h0, 16'h0, "R6 negated above on equal");
    // jumps, jump-and-link next to a never-skip
    issue(1, 3'd1, 0, 0, 0, 16'h0000, 16'h0,    16'hbeef, 16'h0042, "R8 jump taken");
    issue(1, 3'd1, 1, 0, 0, 16'h0000, 16'h0,    16'hbeef, 16'h0042, "R8 jump not taken R6");
    issue(1, 3'd0, 1, 0, 0, 16'h5555, 16'h0,    16'hc0de, 16'h2468, "R9 jump and link");
    issue(0, 3'd0, 1, 1, 0, 16'h5555, 16'h0,    16'hc0de, 16'h2468, "R10 never skip");
    issue(1, 3'd0, 0, 0, 0, 16'h0000, 16'h0,    16'h0777, 16'h1357, "R9 plain jump no link");
    issue(0, 3'd0, 0, 1, 0, 16'h0000, 16'h0,    16'h0,    16'h0,    "R7 always skip far");
    @(negedge clk);
    @(negedge clk);
    // sweep over all codes, kinds and flags
    for (int p = 0; p < 4; p++) begin
      logic [W-1:0] va, vb;
      case (p)
        0: begin va = 16'h0000; vb = 16'h0000; end
        1: begin va = 16'h7fff; vb = 16'h8000; end
        2: begin va = 16'h8001; vb = 16'h8000; end
        default: begin va = 16'h0005; vb = 16'hfffb; end
      endcase
      for (int k = 0; k < 32; k++) begin
        issue(k[4], k[2:0], k[3], k[0], p[0], va, vb, 16'h3000 + W'(k),
              16'h4000 + W'(k), "R3 R4 R5 R6 R7 R8 R9 sweep");
      end
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check("R2 all results delivered", W'(sb.size()), 0);
    finish_run();
  end

endmodule